// File: doc/BRIEF.md
# Flash Chip-Select Timing Controller

This block owns the active-low chip-select line of a serial flash device. A sequencer raises a request when it wants to run an access; the controller pulls chip-select low, waits a selectable setup interval, and then grants the sequencer permission to start clocking. When the sequencer reports that the last clock edge has gone out, the controller waits a selectable release interval before letting chip-select rise. It then keeps the line high for a programmable minimum deselect time before it will start another access.

All intervals are measured in half serial-clock periods. A `half_tick` pulse, one clock wide, marks each half period, so setup and release can sit 0.5 or 1.5 cycles away from the clock edges. After an access the controller can optionally keep chip-select low for a hold window of 32 or 128 serial-clock cycles, or without limit. A request that continues the previous address during that window is granted at once, and chip-select stays low, so no new command phase is needed. A non-sequential request, or the end of the window, closes the access and starts the full deselect time. Dropping `en` or raising the synchronous `rst` forces chip-select high in the same cycle.

The controller is a six-state machine. ST_IDLE (deselected, idle time satisfied) goes to ST_SETUP on a request. ST_SETUP (selected, counting setup) goes to ST_ACTIVE when the setup count expires. ST_ACTIVE (grant high) goes to ST_RELEASE on `xfer_done`. ST_RELEASE goes to ST_GAP when no hold is configured, or to ST_HOLD otherwise. ST_HOLD returns to ST_ACTIVE on a sequential request (a continuation). It goes to ST_GAP on a non-sequential request or when the window expires. ST_GAP (deselected, counting idle time) returns to ST_IDLE on expiry. While `en` is low, every selected state moves to ST_GAP.

Top module: `flash_cs_timer`

## Requirements
- R1: While `rst` is high or `en` is low, `cs_n` is 1 and `grant` is 0 in that same cycle, and requests are not accepted; clearing `en` during an access ends it.
- R2: A request accepted in ST_IDLE drives `cs_n` low on the next clock. `grant` rises after 1 half-tick when `setup_long`=0, or after 3 half-ticks when `setup_long`=1. `grant` never rises in the cycle in which `cs_n` falls.
- R3: After `xfer_done` with `hold_mode`=0, `cs_n` stays low for 1 half-tick (`release_long`=0) or 3 half-ticks (`release_long`=1), then rises. `grant` is already low when `cs_n` rises.
- R4: After `cs_n` rises it stays high for 2*(`idle_len`+1) half-ticks (so `idle_len` value v means v+1 serial cycles, 1 to 16). With a request already pending, `cs_n` falls exactly one clock after that count ends.
- R5: With `hold_mode`=1 or 2, chip-select stays low for a further 64 or 256 half-ticks (32 or 128 serial cycles) after the release interval. If no request arrives, it then rises.
- R6: With `hold_mode`=3, chip-select stays low after the release interval until a request arrives.
- R7: A request with `req_seq`=1 during the hold window is granted on the next clock, with `cs_n` kept low and `grant_cont`=1. `grant_cont` is only ever high together with `grant`, and `grant` only while `cs_n` is low.
- R8: A request with `req_seq`=0 during the hold window raises `cs_n` on the next clock. The full deselect time of R4 and a fresh setup follow, and the grant has `grant_cont`=0.
- R9: All interval counting advances only on clocks with `half_tick`=1; without ticks, chip-select does not change unless a request or `en` changes it.
- R10: Once raised, `grant` stays high until `xfer_done` is seen (or `en` falls).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Controller enable; low forces chip-select high |
| half_tick | input | 1 | One-clock pulse per half serial-clock period |
| req | input | 1 | Access request, held until `grant` |
| req_seq | input | 1 | Request continues the previous address |
| xfer_done | input | 1 | Last serial clock edge of the access has been issued |
| setup_long | input | 1 | 0: 0.5-cycle setup, 1: 1.5-cycle setup |
| release_long | input | 1 | 0: 0.5-cycle release, 1: 1.5-cycle release |
| idle_len | input | IDLE_W (4) | Minimum deselect time minus one, in serial cycles |
| hold_mode | input | 2 | 0 none, 1 32 cycles, 2 128 cycles, 3 unlimited |
| cs_n | output | 1 | Active-low chip-select to the flash |
| grant | output | 1 | Sequencer may clock the access |
| grant_cont | output | 1 | Current grant continues an open access without a command |

## Verification
The properties assume that `half_tick` is a single-clock pulse. They also assume that `req` stays high until `grant` and then drops, and that `xfer_done` only pulses while `grant` is high. The configuration inputs must be stable from a grant until the following deselect has begun. The stimulus drives every input on the falling clock edge. It changes timing fields only while `grant` is high, before `xfer_done`, and pulses `xfer_done` for exactly one clock. It raises the next request at the first falling edge where chip-select is seen high, so the deselect interval can be measured exactly.

// File: rtl/flash_cs_pkg.sv
package flash_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RELEASE,
        ST_HOLD,
        ST_GAP
    } cs_state_e;

    typedef enum logic [1:0] {
        HOLD_NONE    = 2'd0,
        HOLD_SHORT   = 2'd1,
        HOLD_LONG    = 2'd2,
        HOLD_FOREVER = 2'd3
    } hold_mode_e;

    typedef enum logic [1:0] {
        SPAN_SETUP,
        SPAN_RELEASE,
        SPAN_GAP,
        SPAN_HOLD
    } span_sel_e;

endpackage

// File: rtl/flash_cs_span_decode.sv
module flash_cs_span_decode
    import flash_cs_pkg::*;
#(
    parameter int IDLE_W         = 4,
    parameter int HOLD_SHORT_CYC = 32,
    parameter int HOLD_LONG_CYC  = 128,
    parameter int CNT_W          = 9
) (
    input  logic              setup_long,
    input  logic              release_long,
    input  logic [IDLE_W-1:0] idle_len,
    input  logic [1:0]        hold_mode,
    input  span_sel_e         sel,
    output logic [CNT_W-1:0]  span
);

    localparam logic [CNT_W-1:0] HALF_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] HALF_THREE = CNT_W'(3);
    localparam logic [CNT_W-1:0] HOLD_S     = CNT_W'(2 * HOLD_SHORT_CYC);
    localparam logic [CNT_W-1:0] HOLD_L     = CNT_W'(2 * HOLD_LONG_CYC);

    logic [CNT_W-1:0] gap_span;
    logic [CNT_W-1:0] hold_span;

    // Deselect span in half periods: two per serial cycle, stored value plus one.
    assign gap_span = (CNT_W'(idle_len) + CNT_W'(1)) << 1;

    // An unlimited hold loads zero, which the counter never counts down from.
    always_comb begin
        unique case (hold_mode_e'(hold_mode))
            HOLD_SHORT: hold_span = HOLD_S;
            HOLD_LONG:  hold_span = HOLD_L;
            default:    hold_span = '0;
        endcase
    end

    always_comb begin
        unique case (sel)
            SPAN_SETUP:   span = setup_long   ? HALF_THREE : HALF_ONE;
            SPAN_RELEASE: span = release_long ? HALF_THREE : HALF_ONE;
            SPAN_GAP:     span = gap_span;
            SPAN_HOLD:    span = hold_span;
            default:      span = HALF_ONE;
        endcase
    end

endmodule

// File: rtl/flash_cs_span_counter.sv
module flash_cs_span_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // The last tick of a span; a zero count never expires.
    assign expire = tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_cs_timer.sv
module flash_cs_timer
    import flash_cs_pkg::*;
#(
    parameter int IDLE_W         = 4,
    parameter int HOLD_SHORT_CYC = 32,
    parameter int HOLD_LONG_CYC  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              half_tick,
    input  logic              req,
    input  logic              req_seq,
    input  logic              xfer_done,
    input  logic              setup_long,
    input  logic              release_long,
    input  logic [IDLE_W-1:0] idle_len,
    input  logic [1:0]        hold_mode,
    output logic              cs_n,
    output logic              grant,
    output logic              grant_cont
);

    localparam int GAP_TOP  = 1 << IDLE_W;
    localparam int SPAN_TOP = 2 * ((HOLD_LONG_CYC > GAP_TOP) ? HOLD_LONG_CYC : GAP_TOP);
    localparam int CNT_W    = $clog2(SPAN_TOP + 1);

    cs_state_e        state_q, state_d;
    logic             cont_q, cont_d;
    logic             span_load;
    span_sel_e        span_sel;
    logic [CNT_W-1:0] span_val;
    logic             span_expire;
    logic             hold_off;

    assign hold_off = (hold_mode_e'(hold_mode) == HOLD_NONE);

    flash_cs_span_decode #(
        .IDLE_W        (IDLE_W),
        .HOLD_SHORT_CYC(HOLD_SHORT_CYC),
        .HOLD_LONG_CYC (HOLD_LONG_CYC),
        .CNT_W         (CNT_W)
    ) u_decode (
        .setup_long  (setup_long),
        .release_long(release_long),
        .idle_len    (idle_len),
        .hold_mode   (hold_mode),
        .sel         (span_sel),
        .span        (span_val)
    );

    flash_cs_span_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .load    (span_load),
        .load_val(span_val),
        .tick    (half_tick),
        .expire  (span_expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cont_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cont_q  <= cont_d;
        end
    end

    // Next-state and span loading
    always_comb begin
        state_d   = state_q;
        cont_d    = cont_q;
        span_load = 1'b0;
        span_sel  = SPAN_SETUP;
        if (!en) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_GAP: begin
                    if (span_expire) begin
                        state_d = ST_IDLE;
                    end
                end
                default: begin
                    state_d   = ST_GAP;
                    span_load = 1'b1;
                    span_sel  = SPAN_GAP;
                end
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_d   = ST_SETUP;
                        cont_d    = 1'b0;
                        span_load = 1'b1;
                        span_sel  = SPAN_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (span_expire) begin
                        state_d = ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (xfer_done) begin
                        state_d   = ST_RELEASE;
                        span_load = 1'b1;
                        span_sel  = SPAN_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (span_expire) begin
                        span_load = 1'b1;
                        if (hold_off) begin
                            state_d  = ST_GAP;
                            span_sel = SPAN_GAP;
                        end else begin
                            state_d  = ST_HOLD;
                            span_sel = SPAN_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (req && req_seq) begin
                        state_d = ST_ACTIVE;
                        cont_d  = 1'b1;
                    end else if (req || span_expire) begin
                        state_d   = ST_GAP;
                        span_load = 1'b1;
                        span_sel  = SPAN_GAP;
                    end
                end
                ST_GAP: begin
                    if (span_expire) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: chip-select drops out at once on reset or disable
    always_comb begin
        cs_n       = 1'b1;
        grant      = 1'b0;
        grant_cont = 1'b0;
        if (!rst && en) begin
            unique case (state_q)
                ST_SETUP, ST_RELEASE, ST_HOLD: cs_n = 1'b0;
                ST_ACTIVE: begin
                    cs_n       = 1'b0;
                    grant      = 1'b1;
                    grant_cont = cont_q;
                end
                default: cs_n = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/flash_cs_timer_checker.sv
module flash_cs_timer_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic half_tick,
    input logic req,
    input logic xfer_done,
    input logic cs_n,
    input logic grant,
    input logic grant_cont
);

    // R1: disable deselects and withholds the grant
    p_off_deselects_r1: assert property (@(posedge clk) disable iff (rst)
        !en |-> (cs_n && !grant));

    // R2: the grant never comes in the cycle chip-select falls
    p_setup_precedes_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !grant);

    // R2: a rising grant follows a cycle with chip-select already low
    p_grant_after_select_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> $past(!cs_n));

    // R3: during normal operation, release comes only after the grant is gone
    p_release_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n) && en) |-> !$past(grant));

    // R7: the grant lives inside a selected interval
    p_grant_under_select_r7: assert property (@(posedge clk) disable iff (rst)
        grant |-> !cs_n);

    // R7: the continuation flag only accompanies a grant
    p_cont_with_grant_r7: assert property (@(posedge clk) disable iff (rst)
        grant_cont |-> grant);

    // R9: without a tick, request or disable, chip-select does not move
    p_tick_gated_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !half_tick && !req) |=> ($stable(cs_n) || !en));

    // R10: the grant persists until the access is reported done
    p_grant_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (grant && !xfer_done) |=> (grant || !en));

endmodule

bind flash_cs_timer flash_cs_timer_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .half_tick (half_tick),
    .req       (req),
    .xfer_done (xfer_done),
    .cs_n      (cs_n),
    .grant     (grant),
    .grant_cont(grant_cont)
);

// File: tb/flash_cs_timer_test.sv
module flash_cs_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       half_tick = 1'b1;
    logic       req = 1'b0;
    logic       req_seq = 1'b0;
    logic       xfer_done = 1'b0;
    logic       setup_long = 1'b0;
    logic       release_long = 1'b0;
    logic [3:0] idle_len = 4'd0;
    logic [1:0] hold_mode = 2'd0;
    logic       cs_n;
    logic       grant;
    logic       grant_cont;

    int n_cmp = 0;
    int n_bad = 0;

    localparam int K_SETUP = 0;
    localparam int K_TAIL  = 1;
    localparam int K_GAP   = 2;
    localparam int K_CONT  = 3;

    typedef struct {
        int    kind;
        int    val;
        string tag;
    } item_t;

    item_t sbq[$];

    always #4 clk = ~clk;

    flash_cs_timer uut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .half_tick   (half_tick),
        .req         (req),
        .req_seq     (req_seq),
        .xfer_done   (xfer_done),
        .setup_long  (setup_long),
        .release_long(release_long),
        .idle_len    (idle_len),
        .hold_mode   (hold_mode),
        .cs_n        (cs_n),
        .grant       (grant),
        .grant_cont  (grant_cont)
    );

    function automatic string kname(int k);
        case (k)
            K_SETUP: return "setup";
            K_TAIL:  return "tail";
            K_GAP:   return "gap";
            default: return "cont";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(int k, int v, string tag);
        item_t it;
        it.kind = k;
        it.val  = v;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    task automatic observe(int k, int v);
        item_t it;
        if (sbq.size() == 0) begin
            check(1'b0, "R4", {"unexpected ", kname(k), " event"}, v, -1);
        end else begin
            it = sbq.pop_front();
            check((it.kind == k) && ((it.val < 0) || (it.val == v)), it.tag,
                  {kname(it.kind), " interval (seen ", kname(k), ")"}, v, it.val);
        end
    endtask

    // Monitor: measures intervals in clocks, away from the active edge
    bit p_cs = 1'b1;
    bit p_gr = 1'b0;
    bit first = 1'b1;
    int lowc = 0;
    int highc = 0;

    always @(posedge clk) begin
        #2;
        if (rst) begin
            p_cs  = 1'b1;
            p_gr  = 1'b0;
            first = 1'b1;
            lowc  = 0;
            highc = 0;
        end else begin
            if (cs_n && !p_cs) begin
                observe(K_TAIL, lowc);
                lowc  = 0;
                highc = 0;
            end
            if (!cs_n && p_cs) begin
                if (!first) observe(K_GAP, highc);
                first = 1'b0;
                lowc  = 0;
            end
            if (grant && !p_gr) begin
                observe(grant_cont ? K_CONT : K_SETUP, lowc);
                lowc = 0;
            end
            if (cs_n) highc++;
            else if (!grant) lowc++;
            p_cs = cs_n;
            p_gr = grant;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_req(bit seq, bit exp_cont, string tag);
        req     = 1'b1;
        req_seq = seq;
        do @(negedge clk); while (!grant);
        req     = 1'b0;
        req_seq = 1'b0;
        check(grant_cont == exp_cont, tag, "continuation flag", grant_cont, exp_cont);
    endtask

    task automatic finish_xfer();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic wait_cs_high();
        while (!cs_n) @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        wait_n(3);
        check(cs_n == 1'b1, "R1", "cs_n during reset", cs_n, 1);
        check(grant == 1'b0, "R1", "grant during reset", grant, 0);
        rst = 1'b0;
        en  = 1'b1;
        wait_n(1);
        check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);

        // Default timing: half-cycle setup and release, one-cycle idle
        push(K_SETUP, 1, "R2");
        start_req(1'b0, 1'b0, "R2");
        push(K_TAIL, 1, "R3");
        wait_n(2);
        finish_xfer();
        wait_cs_high();
        push(K_GAP, 3, "R4");
        push(K_SETUP, 1, "R2");
        start_req(1'b0, 1'b0, "R4");

        // Long placements and the longest idle time
        setup_long   = 1'b1;
        release_long = 1'b1;
        idle_len     = 4'd15;
        push(K_TAIL, 3, "R3");
        finish_xfer();
        wait_cs_high();
        push(K_GAP, 33, "R4");
        push(K_SETUP, 3, "R2");
        start_req(1'b0, 1'b0, "R2");

        // Short hold window expires without a request
        release_long = 1'b0;
        hold_mode    = 2'd1;
        push(K_TAIL, 65, "R5");
        finish_xfer();
        wait_cs_high();
        push(K_GAP, 33, "R4");
        push(K_SETUP, 3, "R2");
        start_req(1'b0, 1'b0, "R2");

        // Long hold window expires
        setup_long = 1'b0;
        hold_mode  = 2'd2;
        idle_len   = 4'd2;
        push(K_TAIL, 257, "R5");
        finish_xfer();
        wait_cs_high();
        push(K_GAP, 7, "R4");
        push(K_SETUP, 1, "R2");
        start_req(1'b0, 1'b0, "R2");

        // Sequential continuation inside the window
        hold_mode = 2'd1;
        finish_xfer();
        wait_n(10);
        check(cs_n == 1'b0, "R5", "cs_n inside hold window", cs_n, 0);
        push(K_CONT, -1, "R7");
        start_req(1'b1, 1'b1, "R7");

        // Non-sequential request inside the window
        finish_xfer();
        wait_n(5);
        push(K_TAIL, -1, "R8");
        push(K_GAP, 7, "R8");
        push(K_SETUP, 1, "R8");
        start_req(1'b0, 1'b0, "R8");

        // Unlimited hold
        hold_mode = 2'd3;
        finish_xfer();
        wait_n(300);
        check(cs_n == 1'b0, "R6", "cs_n after long unlimited hold", cs_n, 0);
        push(K_CONT, -1, "R6");
        start_req(1'b1, 1'b1, "R6");

        // No ticks: release stalls
        hold_mode = 2'd0;
        half_tick = 1'b0;
        push(K_TAIL, -1, "R9");
        finish_xfer();
        wait_n(20);
        check(cs_n == 1'b0, "R9", "cs_n with ticks stopped", cs_n, 0);
        half_tick = 1'b1;
        wait_cs_high();
        push(K_GAP, 7, "R4");
        push(K_SETUP, 1, "R2");
        start_req(1'b0, 1'b0, "R2");

        // Grant persists, then disable ends the access at once
        wait_n(30);
        check(grant == 1'b1, "R10", "grant before done", grant, 1);
        push(K_TAIL, 0, "R1");
        en = 1'b0;
        #1;
        check(cs_n == 1'b1, "R1", "cs_n on disable", cs_n, 1);
        check(grant == 1'b0, "R1", "grant on disable", grant, 0);
        req = 1'b1;
        wait_n(10);
        check(cs_n == 1'b1, "R1", "cs_n with request while disabled", cs_n, 1);
        check(grant == 1'b0, "R1", "grant with request while disabled", grant, 0);
        push(K_GAP, -1, "R4");
        push(K_SETUP, 1, "R2");
        en = 1'b1;
        start_req(1'b0, 1'b0, "R1");
        push(K_TAIL, 1, "R3");
        finish_xfer();
        wait_cs_high();
        wait_n(5);
        check(sbq.size() == 0, "R3", "expected intervals left unseen", sbq.size(), 0);

        report();
        $finish;
    end

endmodule